// File: doc/BRIEF.md
# Packed Colour Lookup Table

This block is a 256-entry colour lookup table for a display pipeline. Software sees it as 128 words of 32 bits in a byte-addressed window. Each word packs two 16-bit colour entries. Every entry holds three 5-bit channels and one intensity flag. The bus port writes or reads a whole word at a time. A write always replaces both entries held in that word.

The pixel port takes an 8-bit index together with a valid strobe. One clock later it presents the selected entry as a 24-bit colour and raises an output valid. Each 5-bit channel is widened to 8 bits by appending three zero bits. The intensity flag is kept in storage and returned on bus reads, but it has no effect on the colour output.

The pixel port and the bus port may fire in the same cycle, even on the same word. In that case the lookup always sees the contents from before the write.

Top module: `clut_palette`

## Requirements
- R1: The table answers only byte addresses 0x200 through 0x3FF. Word n sits at 0x200 + 4n, and address bits 1:0 are ignored. A write outside the window changes no entry. A read outside the window returns zero.
- R2: Word n carries colour entry 2n in bits 15:0 and colour entry 2n+1 in bits 31:16. An odd pixel index therefore selects the upper half of word index>>1.
- R3: Inside an entry, bits 4:0 are red, bits 9:5 are green and bits 14:10 are blue. The output places red in rgb_out[23:16], green in rgb_out[15:8] and blue in rgb_out[7:0].
- R4: Each output channel equals its 5-bit field shifted left by three, so the low three bits of every output byte are zero.
- R5: Entry bit 15 (intensity) never changes rgb_out, yet it is stored and read back.
- R6: A bus read issued in cycle k presents in cycle k+1 exactly the 32-bit value last written to that word.
- R7: A pixel request with pix_valid high in cycle k gives rgb_valid high and the colour in cycle k+1. rgb_valid is low in the cycle after a cycle with no request.
- R8: When a bus write and a pixel lookup address the same word in the same cycle, the lookup returns the colour from before the write. A later lookup sees the new value.
- R9: Synchronous active-high reset clears every entry. After reset, every lookup yields black, every in-window read yields zero, and rgb_valid, rgb_out and bus_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data (two packed entries) |
| bus_rdata | output | 32 | Read data, valid the cycle after a read; held otherwise |
| pix_valid | input | 1 | Pixel lookup request |
| pix_index | input | 8 | Colour entry index |
| rgb_valid | output | 1 | Colour output valid |
| rgb_out | output | 24 | Expanded colour {red, green, blue} |

## Verification
Both result paths have a single register stage. A colour is therefore due exactly one clock after its pixel request, and read data is due exactly one clock after its bus read. The driver tasks tag each expected item with the cycle count at which it must appear. The monitor samples on the falling edge and flags any item that shows up early, shows up late, or never shows up. For writes, the only visible effect comes in later cycles, so their results are checked through later bus reads and lookups. The collision cases put the write and the lookup in the same cycle and expect the colour from before the write.

// File: rtl/clut_pkg.sv
package clut_pkg;

    parameter int ADDR_W    = 12;
    parameter int WORD_W    = 32;
    parameter int N_WORDS   = 128;
    parameter int WIN_BASE  = 'h200;
    parameter int CH_W      = 5;
    parameter int OUT_CH_W  = 8;

    localparam int ENTRY_W  = WORD_W / 2;
    localparam int N_ENTRY  = N_WORDS * 2;
    localparam int WIDX_W   = $clog2(N_WORDS);
    localparam int IDX_W    = $clog2(N_ENTRY);
    localparam int PAD_W    = OUT_CH_W - CH_W;
    localparam int RGB_W    = 3 * OUT_CH_W;

    typedef struct packed {
        logic            intens;
        logic [CH_W-1:0] blu;
        logic [CH_W-1:0] grn;
        logic [CH_W-1:0] red;
    } pal_entry_t;

    typedef struct packed {
        logic [OUT_CH_W-1:0] r;
        logic [OUT_CH_W-1:0] g;
        logic [OUT_CH_W-1:0] b;
    } rgb_t;

    function automatic pal_entry_t pick_half(input logic [WORD_W-1:0] word,
                                             input logic upper);
        return upper ? pal_entry_t'(word[WORD_W-1:ENTRY_W])
                     : pal_entry_t'(word[ENTRY_W-1:0]);
    endfunction

    function automatic rgb_t widen(input pal_entry_t e);
        rgb_t o;
        o.r = {e.red, {PAD_W{1'b0}}};
        o.g = {e.grn, {PAD_W{1'b0}}};
        o.b = {e.blu, {PAD_W{1'b0}}};
        return o;
    endfunction

endpackage

// File: rtl/clut_decode.sv
module clut_decode
    import clut_pkg::*;
#(
    parameter int A_W   = ADDR_W,
    parameter int BASE  = WIN_BASE,
    parameter int WORDS = N_WORDS,
    parameter int WI_W  = $clog2(WORDS)
) (
    input  logic [A_W-1:0]  addr,
    output logic            hit,
    output logic [WI_W-1:0] widx
);
    localparam logic [A_W:0] LO = (A_W+1)'(BASE);
    localparam logic [A_W:0] HI = (A_W+1)'(BASE + WORDS * 4);

    always_comb begin
        hit  = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
        widx = WI_W'(({1'b0, addr} - LO) >> 2);
    end
endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int WORDS = N_WORDS,
    parameter int W     = WORD_W,
    parameter int WI_W  = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [WI_W-1:0] waddr,
    input  logic [W-1:0]    wdata,
    input  logic [WI_W-1:0] raddr_a,
    output logic [W-1:0]    rdata_a,
    input  logic [WI_W-1:0] raddr_b,
    output logic [W-1:0]    rdata_b
);
    logic [W-1:0] rows [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_row
        logic [W-1:0] row_q;
        always_ff @(posedge clk) begin
            if (rst)
                row_q <= '0;
            else if (we && (waddr == WI_W'(g)))
                row_q <= wdata;
        end
        assign rows[g] = row_q;
    end

    // Reads see the contents before any write on the same edge.
    always_comb begin
        rdata_a = rows[raddr_a];
        rdata_b = rows[raddr_b];
    end
endmodule

// File: rtl/clut_lookup.sv
module clut_lookup
    import clut_pkg::*;
#(
    parameter int IW   = IDX_W,
    parameter int WI_W = IDX_W - 1,
    parameter int W    = WORD_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [IW-1:0]   req_index,
    output logic [WI_W-1:0] word_sel,
    input  logic [W-1:0]    word_in,
    output logic            out_valid,
    output rgb_t            out_rgb
);
    pal_entry_t entry_q;
    logic       valid_q;

    assign word_sel = req_index[IW-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            entry_q <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid)
                entry_q <= pick_half(word_in, req_index[0]);
        end
    end

    assign out_valid = valid_q;
    assign out_rgb   = widen(entry_q);
endmodule

// File: rtl/clut_palette.sv
module clut_palette
    import clut_pkg::*;
#(
    parameter int A_W   = ADDR_W,
    parameter int W     = WORD_W,
    parameter int WORDS = N_WORDS,
    parameter int BASE  = WIN_BASE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [A_W-1:0]       bus_addr,
    input  logic [W-1:0]         bus_wdata,
    output logic [W-1:0]         bus_rdata,
    input  logic                 pix_valid,
    input  logic [$clog2(2*WORDS)-1:0] pix_index,
    output logic                 rgb_valid,
    output logic [RGB_W-1:0]     rgb_out
);
    localparam int WI_W = $clog2(WORDS);
    localparam int IW   = WI_W + 1;

    logic            bus_hit;
    logic [WI_W-1:0] bus_widx;
    logic [WI_W-1:0] pix_widx;
    logic [W-1:0]    bus_word;
    logic [W-1:0]    pix_word;
    logic [W-1:0]    rdata_q;
    rgb_t            rgb_s;

    clut_decode #(.A_W(A_W), .BASE(BASE), .WORDS(WORDS), .WI_W(WI_W)) u_dec (
        .addr (bus_addr),
        .hit  (bus_hit),
        .widx (bus_widx)
    );

    clut_store #(.WORDS(WORDS), .W(W), .WI_W(WI_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_sel && bus_we && bus_hit),
        .waddr   (bus_widx),
        .wdata   (bus_wdata),
        .raddr_a (bus_widx),
        .rdata_a (bus_word),
        .raddr_b (pix_widx),
        .rdata_b (pix_word)
    );

    clut_lookup #(.IW(IW), .WI_W(WI_W), .W(W)) u_look (
        .clk       (clk),
        .rst       (rst),
        .req_valid (pix_valid),
        .req_index (pix_index),
        .word_sel  (pix_widx),
        .word_in   (pix_word),
        .out_valid (rgb_valid),
        .out_rgb   (rgb_s)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (bus_sel && !bus_we)
            rdata_q <= bus_hit ? bus_word : '0;
    end

    assign bus_rdata = rdata_q;
    assign rgb_out   = rgb_s;
endmodule

// File: rtl/clut_palette_checks.sv
module clut_palette_checks
    import clut_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        pix_valid,
    input logic        rgb_valid,
    input logic [23:0] rgb_out
);
    logic in_win;
    assign in_win = (bus_addr >= 12'h200) && (bus_addr <= 12'h3FF);

    // R7: a request yields a valid colour on the next cycle
    a_r7_valid_next: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> rgb_valid);

    // R7: no request, no valid colour next cycle
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !rgb_valid);

    // R4: low three bits of every output byte are zero
    a_r4_pad_zero: assert property (@(posedge clk) disable iff (rst)
        rgb_valid |-> (rgb_out[2:0] == 3'd0 && rgb_out[10:8] == 3'd0
                       && rgb_out[18:16] == 3'd0));

    // R1: out-of-window reads return zero
    a_r1_outside_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && !in_win) |=> (bus_rdata == 32'd0));

    // R6: a read right after a write to the same word returns the written data
    a_r6_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && in_win && $past(bus_sel && bus_we && in_win)
         && bus_addr[11:2] == $past(bus_addr[11:2]))
        |=> (bus_rdata == $past(bus_wdata, 2)));
endmodule

bind clut_palette clut_palette_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pix_valid (pix_valid),
    .rgb_valid (rgb_valid),
    .rgb_out   (rgb_out)
);

// File: tb/tb_clut_palette.sv
`timescale 1ns/1ps
module tb_clut_palette;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_index = '0;
    logic        rgb_valid;
    logic [23:0] rgb_out;

    always #2 clk = ~clk;

    clut_palette dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_valid(pix_valid), .pix_index(pix_index),
        .rgb_valid(rgb_valid), .rgb_out(rgb_out)
    );

    typedef struct {
        int          cyc;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t        rgb_q[$];
    exp_t        rd_q[$];
    logic [31:0] mdl [128];
    int          cycles = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    always @(posedge clk) cycles++;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [31:0] exp_rgb(input logic [7:0] idx);
        logic [15:0] e;
        e = idx[0] ? mdl[idx >> 1][31:16] : mdl[idx >> 1][15:0];
        return {8'd0, e[4:0], 3'd0, e[9:5], 3'd0, e[14:10], 3'd0};
    endfunction

    function automatic bit in_win(input logic [11:0] a);
        return (a >= 12'h200) && (a <= 12'h3FF);
    endfunction

    task automatic release_inputs();
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
        bus_we = 1'b0;
        pix_valid = 1'b0;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        if (in_win(a)) mdl[(a - 12'h200) >> 2] = d;
        release_inputs();
    endtask

    task automatic bus_read(input logic [11:0] a, input string tag);
        exp_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        it.cyc = cycles + 1;
        it.val = in_win(a) ? mdl[(a - 12'h200) >> 2] : 32'd0;
        it.tag = tag;
        rd_q.push_back(it);
        release_inputs();
    endtask

    task automatic lookup(input logic [7:0] idx, input string tag);
        exp_t it;
        @(negedge clk);
        pix_valid = 1'b1; pix_index = idx;
        it.cyc = cycles + 1; it.val = exp_rgb(idx); it.tag = tag;
        rgb_q.push_back(it);
        release_inputs();
    endtask

    // Write and lookup in one cycle; the lookup expects the old contents.
    task automatic collide(input logic [11:0] a, input logic [31:0] d,
                           input logic [7:0] idx);
        exp_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        pix_valid = 1'b1; pix_index = idx;
        it.cyc = cycles + 1; it.val = exp_rgb(idx); it.tag = "R8 collision";
        rgb_q.push_back(it);
        mdl[(a - 12'h200) >> 2] = d;
        release_inputs();
    endtask

    // Monitor: compares results at their due cycle.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rgb_valid) begin
                if (rgb_q.size() == 0) begin
                    chk(0, "R7 unexpected rgb_valid", {8'd0, rgb_out}, 32'd0);
                end else begin
                    exp_t it;
                    it = rgb_q.pop_front();
                    chk(it.cyc == cycles, {it.tag, " R7 timing"}, cycles, it.cyc);
                    chk({8'd0, rgb_out} == it.val, it.tag, {8'd0, rgb_out}, it.val);
                end
            end else if (rgb_q.size() > 0 && rgb_q[0].cyc <= cycles) begin
                exp_t it;
                it = rgb_q.pop_front();
                chk(0, {it.tag, " R7 missing rgb_valid"}, 32'd0, it.val);
            end
            if (rd_q.size() > 0 && rd_q[0].cyc == cycles) begin
                exp_t it;
                it = rd_q.pop_front();
                chk(bus_rdata == it.val, it.tag, bus_rdata, it.val);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(rgb_valid == 1'b0, "R9 rgb_valid in reset", {31'd0, rgb_valid}, 32'd0);
        chk(rgb_out == 24'd0, "R9 rgb_out in reset", {8'd0, rgb_out}, 32'd0);
        chk(bus_rdata == 32'd0, "R9 bus_rdata in reset", bus_rdata, 32'd0);
        rst = 1'b0;

        // R9: empty table is black / zero
        lookup(8'd0, "R9 black");
        lookup(8'd255, "R9 black");
        lookup(8'd77, "R9 black");
        bus_read(12'h200, "R9 zero word");
        bus_read(12'h3FC, "R9 zero word");

        // Fill every word with a varied pattern (bit 15/31 set on some)
        for (int w = 0; w < 128; w++)
            bus_write(12'h200 + 12'(4 * w), 32'(w + 1) * 32'h9E3779B9);

        // R6 and R1 (low address bits ignored)
        bus_read(12'h200, "R6 readback word 0");
        bus_read(12'h3FC, "R6 readback word 127");
        bus_read(12'h253, "R1 R6 low address bits ignored");
        bus_read(12'h2A8, "R6 readback word 42");

        // R2 R3 R4 R5: sweep every index, back to back
        for (int i = 0; i < 256; i++) lookup(8'(i), "R2 R3 R4 R5 sweep");

        // R3: one channel at a time
        bus_write(12'h214, 32'h03E0_001F);
        lookup(8'd10, "R3 red only");
        lookup(8'd11, "R3 green only");
        bus_write(12'h218, 32'h0000_7C00);
        lookup(8'd12, "R3 blue only");

        // R5: intensity ignored for colour, kept in storage
        bus_write(12'h21C, 32'hFFFF_7FFF);
        lookup(8'd14, "R5 intensity clear");
        lookup(8'd15, "R5 intensity set");
        bus_write(12'h220, 32'h8000_0000);
        lookup(8'd17, "R5 intensity only is black");
        bus_read(12'h220, "R5 intensity stored");

        // R1: writes outside the window are ignored, reads give zero
        bus_write(12'h000, 32'hDEAD_BEEF);
        bus_write(12'h400, 32'hCAFE_F00D);
        bus_write(12'h1FC, 32'h1234_5678);
        bus_write(12'hFFC, 32'h8765_4321);
        bus_read(12'h200, "R1 word 0 untouched");
        bus_read(12'h3FC, "R1 word 127 untouched");
        lookup(8'd0, "R1 entry 0 untouched");
        lookup(8'd1, "R1 entry 1 untouched");
        bus_read(12'h000, "R1 outside read zero");
        bus_read(12'h400, "R1 outside read zero");
        bus_read(12'h1FC, "R1 outside read zero");

        // R8: same-cycle write and lookup
        collide(12'h20C, 32'h7C00_03E0, 8'd6);
        lookup(8'd6, "R8 new value after collision");
        collide(12'h20C, 32'h001F_7FFF, 8'd7);
        lookup(8'd7, "R8 new value after collision");

        // R7: back-to-back lookups on adjacent entries
        lookup(8'd20, "R7 back to back");
        lookup(8'd21, "R7 back to back");

        repeat (5) @(negedge clk);
        chk(rgb_q.size() == 0, "R7 all colours delivered", rgb_q.size(), 0);
        chk(rd_q.size() == 0, "R6 all reads delivered", rd_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule